// File: doc/BRIEF.md
# Write Interleave Depth Checker

This block is a passive observer for a write path where data beats carry their own transaction ID. It watches the write address channel and the write data channel without driving either one. It keeps an ordered record of every write address it has seen accepted and not yet completed. Each data beat it sees is matched to one of these records. When the traffic breaks an ordering or interleaving rule, it raises an error.

A data beat is checked against several rules:
- the beat must belong to one of the oldest `ILV_DEPTH` pending transactions;
- a transaction's first beat may not arrive while an older transaction has not yet started;
- its ID must name a pending address;
- the last-beat marker must line up with the burst length given on the address.

A beat for an ID that has several pending transactions always goes to the oldest of them. Every detected error sets its own sticky flag, and a one-cycle pulse marks the cycle in which any new error was recorded. The block is placed beside an interconnect or slave port during integration or emulation.

Top module: `wil_checker`

## Requirements
- R1: A write address is recorded only in a cycle with `aw_valid` and `aw_ready` both high. A data beat is evaluated only in a cycle with `w_valid` and `w_ready` both high. Any other cycle leaves the tracker and the flags unchanged.
- R2: Flag bit 0 (order) is set when a data beat is the first beat of its transaction and some older pending transaction has received no beat yet.
- R3: Flag bit 1 (no address) is set when a beat's `w_id` matches no pending transaction. The beat is then discarded. An address accepted in the same cycle does not count as pending for that beat.
- R4: Flag bit 2 (window) is set when a beat belongs to a transaction whose age rank is `ILV_DEPTH` or more, where rank 0 is the oldest pending transaction.
- R5: Flag bit 3 (last) is set when `w_last` differs from "this beat brings the received count to `aw_len`+1". The transaction retires on its final counted beat or on a `w_last` beat, whichever comes first. After retirement, its ID no longer matches it.
- R6: Several pending transactions may share an ID. A beat with that ID is credited to the oldest of them, and younger ones keep their place in order.
- R7: Flag bit 4 (full) is set when an address is accepted while `CAP` transactions are pending after this cycle's retirement. That address is dropped.
- R8: Flags are sticky. `err_pulse_o` is high for exactly the one cycle after an edge on which at least one new error was recorded, and is low otherwise.
- R9: `clear_i` clears all flags at the next edge. An error detected in that same cycle is still recorded.
- R10: While `rst_n` is low, the tracker empties and all flags and the pulse go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Synchronous clear of the sticky flags |
| aw_id | input | ID_W | Write address ID |
| aw_len | input | LEN_W | Burst length minus one |
| aw_valid | input | 1 | Address valid |
| aw_ready | input | 1 | Address ready |
| w_id | input | ID_W | Data beat ID |
| w_last | input | 1 | Last beat marker |
| w_valid | input | 1 | Data valid |
| w_ready | input | 1 | Data ready |
| err_flags_o | output | 5 | Sticky flags: bit0 order, bit1 no address, bit2 window, bit3 last, bit4 full |
| err_pulse_o | output | 1 | One-cycle pulse when any new error was recorded |

## Verification
The bench goes after the case of four pending IDs with a window of two. A checker that counts rank from the youngest entry, or that never checks rank, would miss the beat aimed at the third address. It also drives two pending transactions that share one ID. If beats were credited to the youngest of the two, the bench would see false last-mismatch and order errors.

An address and a data beat with the same ID are presented in one cycle. A design that matched the beat against the same-cycle address would stay silent here instead of flagging it.

The tracker is filled to capacity. A checker that overwrote the oldest entry rather than dropping the new one would later report false no-address errors.

A clear is raised in the same cycle as a fresh error. If clear were given priority, that error would be lost.

// File: rtl/wil_pkg.sv
package wil_pkg;
    localparam int ERR_W      = 5;
    localparam int ERR_ORDER  = 0;
    localparam int ERR_NOADDR = 1;
    localparam int ERR_WINDOW = 2;
    localparam int ERR_LAST   = 3;
    localparam int ERR_FULL   = 4;
endpackage

// File: rtl/wil_match.sv
// Finds the oldest pending entry whose ID equals the key, and reports
// whether an older entry has not yet started.
module wil_match #(
    parameter int ID_W  = 4,
    parameter int CAP   = 8,
    parameter int CNT_W = 4,
    parameter int IDX_W = 3
) (
    input  logic [CAP*ID_W-1:0] ids_i,
    input  logic [CAP-1:0]      started_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [ID_W-1:0]     key_i,
    output logic                hit_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic                older_idle_o
);
    logic [CAP-1:0] eq;
    logic [CAP-1:0] live;

    for (genvar g = 0; g < CAP; g++) begin : g_cmp
        assign live[g] = (g < int'(cnt_i));
        assign eq[g]   = live[g] && (ids_i[g*ID_W +: ID_W] == key_i);
    end

    always_comb begin
        hit_o        = 1'b0;
        idx_o        = '0;
        older_idle_o = 1'b0;
        for (int i = 0; i < CAP; i++) begin
            if (!hit_o) begin
                if (eq[i]) begin
                    hit_o = 1'b1;
                    idx_o = IDX_W'(i);
                end else if (live[i] && !started_i[i]) begin
                    older_idle_o = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wil_checker.sv
module wil_checker
    import wil_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int LEN_W     = 4,
    parameter int CAP       = 8,
    parameter int ILV_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [ID_W-1:0]  aw_id,
    input  logic [LEN_W-1:0] aw_len,
    input  logic             aw_valid,
    input  logic             aw_ready,
    input  logic [ID_W-1:0]  w_id,
    input  logic             w_last,
    input  logic             w_valid,
    input  logic             w_ready,
    output logic [ERR_W-1:0] err_flags_o,
    output logic             err_pulse_o
);
    localparam int CNT_W  = $clog2(CAP + 1);
    localparam int IDX_W  = (CAP > 1) ? $clog2(CAP) : 1;
    localparam int BEAT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);
    localparam logic [IDX_W:0]   WIN_V = (IDX_W + 1)'(ILV_DEPTH);

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [BEAT_W-1:0] need;
        logic [BEAT_W-1:0] got;
        logic              started;
    } ent_t;

    typedef struct packed {
        ent_t [CAP-1:0]   ent;
        logic [CNT_W-1:0] cnt;
        logic [ERR_W-1:0] flags;
        logic             pulse;
    } st_t;

    st_t s_q, s_d;

    logic                aw_fire, w_fire;
    logic [CAP*ID_W-1:0] ids_flat;
    logic [CAP-1:0]      started_vec;
    logic                hit;
    logic [IDX_W-1:0]    idx;
    logic                older_idle;
    logic [ERR_W-1:0]    new_err;
    logic [BEAT_W-1:0]   got_n;
    logic                done;

    assign aw_fire = aw_valid && aw_ready;
    assign w_fire  = w_valid && w_ready;

    always_comb begin
        for (int i = 0; i < CAP; i++) begin
            ids_flat[i*ID_W +: ID_W] = s_q.ent[i].id;
            started_vec[i]           = s_q.ent[i].started;
        end
    end

    wil_match #(.ID_W(ID_W), .CAP(CAP), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_match (
        .ids_i        (ids_flat),
        .started_i    (started_vec),
        .cnt_i        (s_q.cnt),
        .key_i        (w_id),
        .hit_o        (hit),
        .idx_o        (idx),
        .older_idle_o (older_idle)
    );

    always_comb begin
        s_d     = s_q;
        new_err = '0;
        got_n   = s_q.ent[idx].got + 1'b1;
        done    = (got_n == s_q.ent[idx].need);

        // Data side first: it may retire an entry before the new address lands.
        if (w_fire) begin
            if (!hit) begin
                new_err[ERR_NOADDR] = 1'b1;
            end else begin
                if ({1'b0, idx} >= WIN_V)
                    new_err[ERR_WINDOW] = 1'b1;
                if (!s_q.ent[idx].started && older_idle)
                    new_err[ERR_ORDER] = 1'b1;
                if (w_last != done)
                    new_err[ERR_LAST] = 1'b1;
                if (done || w_last) begin
                    for (int i = 0; i < CAP - 1; i++)
                        if (i >= int'(idx)) s_d.ent[i] = s_q.ent[i+1];
                    s_d.ent[CAP-1] = '0;
                    s_d.cnt        = s_q.cnt - 1'b1;
                end else begin
                    s_d.ent[idx].got     = got_n;
                    s_d.ent[idx].started = 1'b1;
                end
            end
        end

        if (aw_fire) begin
            if (s_d.cnt == CAP_V) begin
                new_err[ERR_FULL] = 1'b1;
            end else begin
                for (int i = 0; i < CAP; i++) begin
                    if (i == int'(s_d.cnt)) begin
                        s_d.ent[i].id      = aw_id;
                        s_d.ent[i].need    = {1'b0, aw_len} + 1'b1;
                        s_d.ent[i].got     = '0;
                        s_d.ent[i].started = 1'b0;
                    end
                end
                s_d.cnt = s_d.cnt + 1'b1;
            end
        end

        s_d.flags = (clear_i ? '0 : s_q.flags) | new_err;
        s_d.pulse = |new_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign err_flags_o = s_q.flags;
    assign err_pulse_o = s_q.pulse;

    // R3: a beat seen with nothing pending must leave the no-address flag set.
    assert_noaddr_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (w_fire && s_q.cnt == '0) |=> err_flags_o[ERR_NOADDR]);

    // R7: an address arriving at a full tracker is refused and flagged.
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_fire && !w_fire && s_q.cnt == CAP_V) |=> (err_flags_o[ERR_FULL] && s_q.cnt == CAP_V));

    // R8: the pulse always comes with at least one raised flag.
    assert_pulse_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> (err_flags_o != '0));

    // R8: without a clear, no flag ever drops.
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((err_flags_o & $past(err_flags_o)) == $past(err_flags_o)));

    // R9: a clear in a quiet cycle empties every flag.
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !w_fire && !aw_fire) |=> (err_flags_o == '0 && !err_pulse_o));

    // R1: nothing changes when neither channel hands over.
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_fire && !aw_fire && !clear_i) |=> ($stable(s_q.cnt) && !err_pulse_o));
endmodule

// File: tb/tb_wil_checker.sv
module tb_wil_checker;
    localparam int CAP = 8;
    localparam int DEPTH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic [3:0] aw_id = '0;
    logic [3:0] aw_len = '0;
    logic       aw_valid = 1'b0, aw_ready = 1'b0;
    logic [3:0] w_id = '0;
    logic       w_last = 1'b0, w_valid = 1'b0, w_ready = 1'b0;
    logic [4:0] err_flags_o;
    logic       err_pulse_o;

    always #4 clk = ~clk;

    wil_checker #(.ID_W(4), .LEN_W(4), .CAP(CAP), .ILV_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .aw_id(aw_id), .aw_len(aw_len), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .w_id(w_id), .w_last(w_last), .w_valid(w_valid), .w_ready(w_ready),
        .err_flags_o(err_flags_o), .err_pulse_o(err_pulse_o)
    );

    int n_vec = 0;
    int n_bad = 0;

    // Bench model of the pending list, oldest at index 0.
    int   m_id[CAP];
    int   m_need[CAP];
    int   m_got[CAP];
    bit   m_st[CAP];
    int   m_cnt = 0;
    logic [4:0] exp_flags = '0;
    logic       exp_pulse = 1'b0;

    function automatic logic [4:0] model_step(bit awf, int aid, int alen,
                                              bit wf, int wid, bit wl, bit clr);
        logic [4:0] ne = '0;
        if (wf) begin
            int j = -1;
            for (int k = 0; k < m_cnt; k++) if (j < 0 && m_id[k] == wid) j = k;
            if (j < 0) ne[1] = 1'b1;
            else begin
                int g;
                bit fin;
                if (j >= DEPTH) ne[2] = 1'b1;
                if (!m_st[j]) for (int k = 0; k < j; k++) if (!m_st[k]) ne[0] = 1'b1;
                g   = m_got[j] + 1;
                fin = (g == m_need[j]);
                if (wl != fin) ne[3] = 1'b1;
                if (fin || wl) begin
                    for (int k = j; k < m_cnt - 1; k++) begin
                        m_id[k] = m_id[k+1]; m_need[k] = m_need[k+1];
                        m_got[k] = m_got[k+1]; m_st[k] = m_st[k+1];
                    end
                    m_cnt--;
                end else begin
                    m_got[j] = g; m_st[j] = 1'b1;
                end
            end
        end
        if (awf) begin
            if (m_cnt == CAP) ne[4] = 1'b1;
            else begin
                m_id[m_cnt] = aid; m_need[m_cnt] = alen + 1;
                m_got[m_cnt] = 0; m_st[m_cnt] = 1'b0; m_cnt++;
            end
        end
        exp_flags = (clr ? 5'b0 : exp_flags) | ne;
        exp_pulse = |ne;
        return ne;
    endfunction

    task automatic check(string req);
        n_vec++;
        if (err_flags_o !== exp_flags || err_pulse_o !== exp_pulse) begin
            n_bad++;
            $display("FAIL %s: flags=%b pulse=%b expected flags=%b pulse=%b",
                     req, err_flags_o, err_pulse_o, exp_flags, exp_pulse);
        end
    endtask

    // Called at a falling edge; applies one cycle of stimulus and checks after the edge.
    task automatic step(bit awv, bit awr, int aid, int alen,
                        bit wv, bit wr, int wid, bit wl, bit clr, string req);
        logic [4:0] unused;
        aw_valid = awv; aw_ready = awr; aw_id = 4'(aid); aw_len = 4'(alen);
        w_valid = wv; w_ready = wr; w_id = 4'(wid); w_last = wl; clear_i = clr;
        unused = model_step(awv && awr, aid, alen, wv && wr, wid, wl, clr);
        @(posedge clk);
        #2;
        check(req);
        @(negedge clk);
    endtask

    task automatic addr(int aid, int alen, string req);
        step(1, 1, aid, alen, 0, 0, 0, 0, 0, req);
    endtask

    task automatic beat(int wid, bit wl, string req);
        step(0, 0, 0, 0, 1, 1, wid, wl, 0, req);
    endtask

    task automatic idle(string req);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        aw_valid = 0; w_valid = 0; clear_i = 0;
        @(posedge clk); @(posedge clk);
        #2;
        m_cnt = 0; exp_flags = '0; exp_pulse = 1'b0;
        check("R10 reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();

        // R1: handshake halves alone record nothing.
        step(1, 0, 5, 0, 0, 1, 0, 0, 0, "R1 aw without ready");
        step(0, 0, 0, 0, 1, 0, 5, 1, 0, "R1 w without ready");
        beat(5, 1, "R1 unrecorded address gives no-address");
        do_reset();

        // R2: first beat of the younger transaction before the older one starts.
        addr(0, 1, "R2 setup");
        addr(1, 1, "R2 setup");
        beat(1, 0, "R2 out-of-order first beat");
        beat(0, 0, "R2 older starts");
        beat(1, 1, "R2");
        beat(0, 1, "R2");
        do_reset();

        // R3: empty tracker, and same-cycle address plus beat.
        beat(9, 1, "R3 empty tracker");
        step(1, 1, 6, 0, 1, 1, 6, 1, 0, "R3 same-cycle address not pending");
        beat(6, 1, "R3 address now pending, legal");
        do_reset();

        // R4: depth two, four pending IDs; third address is outside the window.
        addr(0, 0, "R4 setup"); addr(1, 0, "R4 setup");
        addr(2, 0, "R4 setup"); addr(3, 0, "R4 setup");
        beat(0, 1, "R4 in window");
        beat(2, 1, "R4 rank one after retire, in window");
        beat(3, 1, "R4 rank one");
        beat(1, 1, "R4 rank zero");
        addr(4, 0, "R4 setup"); addr(5, 0, "R4 setup"); addr(7, 0, "R4 setup");
        beat(7, 1, "R4 rank two outside window");
        do_reset();

        // R5: early last, and missing last.
        addr(2, 2, "R5 setup");
        beat(2, 0, "R5");
        beat(2, 1, "R5 early last");
        beat(2, 1, "R5 retired on early last");
        addr(3, 0, "R5 setup");
        beat(3, 0, "R5 missing last");
        do_reset();

        // R6: shared ID, oldest first, no errors expected.
        addr(3, 0, "R6 setup");
        addr(3, 1, "R6 setup");
        beat(3, 1, "R6 single beat to oldest");
        beat(3, 0, "R6 younger starts");
        beat(3, 1, "R6 younger ends");
        idle("R6 clean");
        do_reset();

        // R7: fill to capacity then overflow; retire-and-add in same cycle fits.
        for (int i = 0; i < CAP; i++) addr(i, 0, "R7 fill");
        addr(12, 0, "R7 overflow dropped");
        beat(12, 1, "R7 dropped address not pending");
        step(1, 1, 13, 0, 1, 1, 0, 1, 0, "R7 retire frees slot same cycle");
        do_reset();

        // R8 and R9: pulse width, stickiness, clear versus fresh error.
        beat(1, 1, "R8 make error");
        idle("R8 pulse drops, flag stays");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 clear");
        idle("R9 cleared");
        beat(4, 1, "R8 new error");
        step(0, 0, 0, 0, 1, 1, 4, 1, 1, "R9 clear with fresh error");
        do_reset();

        // Random traffic.
        for (int n = 0; n < 4000; n++) begin
            int wid;
            bit wl;
            int sel;
            sel = (m_cnt > 0) ? ((($urandom % 4) != 0) ? 0 : int'($urandom % m_cnt)) : 0;
            wid = (m_cnt > 0 && ($urandom % 8) != 0) ? m_id[sel] : int'($urandom % 5);
            wl  = (m_cnt > 0 && ($urandom % 10) != 0) ? (m_got[sel] + 1 == m_need[sel])
                                                       : bit'($urandom % 2);
            step(($urandom % 3) != 0, ($urandom % 4) != 0, int'($urandom % 4), int'($urandom % 3),
                 ($urandom % 3) != 0, ($urandom % 4) != 0, wid, wl,
                 ($urandom % 40) == 0, "random R2 R3 R4 R5 R6 R7 R8 R9");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule